// File: doc/BRIEF.md
# Interrupt Acceptance and Refresh Controller

This block holds the interrupt-enable state of an 8-bit processor core and decides, at each instruction boundary, whether a maskable or a non-maskable request is taken. It sits beside the instruction sequencer. The decoder sends it one-cycle strobes for enable, disable, restore-from-NMI, halt entry, opcode fetch and interrupt-mode selection. It also receives a level that is high while an index prefix is still waiting for its opcode. The block replies with one-cycle accept pulses and exposes the two enable flip-flops, the halt status and the interrupt-mode value.

The block also keeps the interrupt-page register and the memory-refresh register. The seven low refresh bits count opcode fetches and wrap around. The top bit keeps whatever software last wrote. A combined 16-bit view places the page register above the refresh register. Vector fetch and dispatch after an accept belong to the sequencer.

Top module: `intacc_top`

## Requirements
- R1: After rst_n low or a restart_i strobe: iff1_o, iff2_o, halted_o, ei_shadow_o, both accept pulses, mode_o, page_o and refresh_o are all 0.
- R2: An enable strobe sets both flip-flops and ei_shadow_o. ei_shadow_o returns to 0 on the next fetch_i strobe.
- R3: A disable strobe clears both flip-flops. A restore strobe copies iff2_o into iff1_o.
- R4: No request is accepted at a boundary while prefix_i is high or ei_shadow_o is high.
- R5: A maskable request is accepted when boundary_i is high, irq_i is high, iff1_o is 1 and R4 does not block. irq_ack_o is high for exactly the one cycle after that boundary cycle. Acceptance clears both flip-flops.
- R6: A rising edge of nmi_i is held as pending and is accepted at the next allowed boundary whatever iff1_o is. Acceptance pulses nmi_ack_o for one cycle, clears iff1_o, leaves iff2_o unchanged and drops the pending request. A level held high does not cause a second accept.
- R7: When both requests can be taken in the same cycle, only the non-maskable one is accepted. The two accept pulses are never high together.
- R8: Each fetch_i strobe adds 1 to refresh_o bits 6:0, wrapping from 7F to 00. Bit 7 is not changed.
- R9: A refresh write loads all 8 bits of refresh_o from wdata_i. A page write loads page_o. pair_o equals {page_o, refresh_o}.
- R10: A halt strobe sets halted_o. A fetch_i while halted still counts the refresh register and keeps halted_o at 1. Any accepted request clears halted_o.
- R11: A mode write loads the 2-bit mode_i into mode_o (values 0, 1 and 2 are the modes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart strobe, same effect as reset |
| en_i | input | 1 | Enable-interrupts strobe |
| dis_i | input | 1 | Disable-interrupts strobe |
| restore_i | input | 1 | Copy iff2 into iff1 |
| halt_i | input | 1 | Halt entry strobe |
| fetch_i | input | 1 | Opcode-fetch strobe |
| prefix_i | input | 1 | Index prefix pending level |
| boundary_i | input | 1 | Instruction boundary, acceptance is sampled here |
| page_wr_i | input | 1 | Write page register |
| refresh_wr_i | input | 1 | Write refresh register |
| wdata_i | input | 8 | Write data for page/refresh |
| mode_wr_i | input | 1 | Write interrupt mode |
| mode_i | input | 2 | Interrupt mode value |
| irq_i | input | 1 | Maskable request level |
| nmi_i | input | 1 | Non-maskable request line, edge sensitive |
| irq_ack_o | output | 1 | Maskable accept pulse |
| nmi_ack_o | output | 1 | Non-maskable accept pulse |
| iff1_o | output | 1 | Enable flip-flop 1 |
| iff2_o | output | 1 | Enable flip-flop 2 |
| ei_shadow_o | output | 1 | Last instruction was an enable |
| halted_o | output | 1 | Halt status |
| mode_o | output | 2 | Interrupt mode |
| page_o | output | 8 | Interrupt page register |
| refresh_o | output | 8 | Refresh register |
| pair_o | output | 16 | Page and refresh combined |

## Verification
The assertions check on every cycle that an accept only follows a boundary at which acceptance was allowed, that a maskable accept only follows a set iff1, that the two pulses are exclusive, and that enable and disable leave the flip-flops in their stated state. They also check that refresh bit 7 does not move without a write. The bench scenarios are needed for the rest: the order of effects across several instructions, edge-versus-level handling of the non-maskable line, the wrap of the refresh counter, halt exit on an accept, and the exact cycle in which each pulse appears.

// File: rtl/intacc_pkg.sv
package intacc_pkg;
  localparam int REG_W  = 8;
  localparam int MODE_W = 2;
  localparam int CNT_W  = REG_W - 1;

  // low bits count, top bit held
  function automatic logic [REG_W-1:0] refresh_step(input logic [REG_W-1:0] r);
    logic [CNT_W-1:0] low;
    low = r[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1};
    return {r[REG_W-1], low};
  endfunction

  function automatic logic [2*REG_W-1:0] pair_of(input logic [REG_W-1:0] pg,
                                                 input logic [REG_W-1:0] r);
    return {pg, r};
  endfunction
endpackage

// File: rtl/intacc_enables.sv
module intacc_enables (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  input  logic dis,
  input  logic restore,
  input  logic fetch,
  input  logic halt_req,
  input  logic take_irq,
  input  logic take_nmi,
  output logic iff1,
  output logic iff2,
  output logic ei_shadow,
  output logic halted
);
  logic any_take;
  logic en_wins;
  assign any_take = take_irq | take_nmi;
  assign en_wins  = en & ~dis & ~any_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1 <= 1'b0; iff2 <= 1'b0; ei_shadow <= 1'b0; halted <= 1'b0;
    end else if (restart) begin
      iff1 <= 1'b0; iff2 <= 1'b0; ei_shadow <= 1'b0; halted <= 1'b0;
    end else begin
      if (take_irq) begin
        iff1 <= 1'b0; iff2 <= 1'b0;
      end else if (take_nmi) begin
        iff1 <= 1'b0;
      end else if (dis) begin
        iff1 <= 1'b0; iff2 <= 1'b0;
      end else if (en) begin
        iff1 <= 1'b1; iff2 <= 1'b1;
      end else if (restore) begin
        iff1 <= iff2;
      end
      if (en_wins)    ei_shadow <= 1'b1;
      else if (fetch) ei_shadow <= 1'b0;
      if (any_take)      halted <= 1'b0;
      else if (halt_req) halted <= 1'b1;
    end
  end

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (!iff1 && !iff2)); // R3
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    en_wins && !restart |=> (iff1 && iff2 && ei_shadow)); // R2
  AST_TAKE_UNHALTS: assert property (@(posedge clk) disable iff (!rst_n)
    any_take |=> !halted); // R10
endmodule

// File: rtl/intacc_arbiter.sv
module intacc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic boundary,
  input  logic prefix,
  input  logic ei_shadow,
  input  logic iff1,
  input  logic irq,
  input  logic nmi,
  output logic take_irq,
  output logic take_nmi,
  output logic irq_ack,
  output logic nmi_ack
);
  logic nmi_d, nmi_pend, nmi_edge, allowed;

  assign nmi_edge = nmi & ~nmi_d;
  assign allowed  = boundary & ~prefix & ~ei_shadow;
  assign take_nmi = allowed & nmi_pend;
  assign take_irq = allowed & irq & iff1 & ~take_nmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d <= 1'b0; nmi_pend <= 1'b0; irq_ack <= 1'b0; nmi_ack <= 1'b0;
    end else if (restart) begin
      nmi_d <= nmi; nmi_pend <= 1'b0; irq_ack <= 1'b0; nmi_ack <= 1'b0;
    end else begin
      nmi_d    <= nmi;
      nmi_pend <= take_nmi ? nmi_edge : (nmi_pend | nmi_edge);
      irq_ack  <= take_irq;
      nmi_ack  <= take_nmi;
    end
  end

  AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || nmi_ack) |-> $past(boundary && !prefix && !ei_shadow)); // R4
  AST_IRQ_NEEDS_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(iff1 && irq)); // R5
  AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, nmi_ack})); // R7
endmodule

// File: rtl/intacc_regs.sv
module intacc_regs
  import intacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              fetch,
  input  logic              page_wr,
  input  logic              refresh_wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_in,
  output logic [REG_W-1:0]  page,
  output logic [REG_W-1:0]  refresh,
  output logic [MODE_W-1:0] mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0; refresh <= '0; mode <= '0;
    end else if (restart) begin
      page <= '0; refresh <= '0; mode <= '0;
    end else begin
      if (page_wr)         page    <= wdata;
      if (refresh_wr)      refresh <= wdata;
      else if (fetch)      refresh <= refresh_step(refresh);
      if (mode_wr)         mode    <= mode_in;
    end
  end

  AST_R7_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_wr && !restart) |=> $stable(refresh[REG_W-1])); // R8
endmodule

// File: rtl/intacc_top.sv
module intacc_top
  import intacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              en_i,
  input  logic              dis_i,
  input  logic              restore_i,
  input  logic              halt_i,
  input  logic              fetch_i,
  input  logic              prefix_i,
  input  logic              boundary_i,
  input  logic              page_wr_i,
  input  logic              refresh_wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              irq_i,
  input  logic              nmi_i,
  output logic              irq_ack_o,
  output logic              nmi_ack_o,
  output logic              iff1_o,
  output logic              iff2_o,
  output logic              ei_shadow_o,
  output logic              halted_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [REG_W-1:0]  page_o,
  output logic [REG_W-1:0]  refresh_o,
  output logic [2*REG_W-1:0] pair_o
);
  logic take_irq_w, take_nmi_w;

  intacc_enables u_en (
    .clk(clk), .rst_n(rst_n), .restart(restart_i), .en(en_i), .dis(dis_i),
    .restore(restore_i), .fetch(fetch_i), .halt_req(halt_i),
    .take_irq(take_irq_w), .take_nmi(take_nmi_w),
    .iff1(iff1_o), .iff2(iff2_o), .ei_shadow(ei_shadow_o), .halted(halted_o)
  );

  intacc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .restart(restart_i), .boundary(boundary_i),
    .prefix(prefix_i), .ei_shadow(ei_shadow_o), .iff1(iff1_o),
    .irq(irq_i), .nmi(nmi_i), .take_irq(take_irq_w), .take_nmi(take_nmi_w),
    .irq_ack(irq_ack_o), .nmi_ack(nmi_ack_o)
  );

  intacc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .restart(restart_i), .fetch(fetch_i),
    .page_wr(page_wr_i), .refresh_wr(refresh_wr_i), .wdata(wdata_i),
    .mode_wr(mode_wr_i), .mode_in(mode_i),
    .page(page_o), .refresh(refresh_o), .mode(mode_o)
  );

  assign pair_o = pair_of(page_o, refresh_o);

  AST_NMI_KEEPS_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi_w && !restart_i) |=> (!iff1_o && iff2_o == $past(iff2_o))); // R6
endmodule

// File: tb/test_intacc_top.sv
module test_intacc_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic restart_i = 0, en_i = 0, dis_i = 0, restore_i = 0, halt_i = 0, fetch_i = 0;
  logic prefix_i = 0, boundary_i = 0, page_wr_i = 0, refresh_wr_i = 0, mode_wr_i = 0;
  logic irq_i = 0, nmi_i = 0;
  logic [7:0] wdata_i = 0;
  logic [1:0] mode_i = 0;
  logic irq_ack_o, nmi_ack_o, iff1_o, iff2_o, ei_shadow_o, halted_o;
  logic [1:0] mode_o;
  logic [7:0] page_o, refresh_o;
  logic [15:0] pair_o;
  int total = 0, failed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intacc_top i_intacc_top (.*);

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_en();  en_i = 1;  tick(); en_i = 0;  endtask
  task automatic pulse_dis(); dis_i = 1; tick(); dis_i = 0; endtask
  task automatic pulse_fetch(); fetch_i = 1; tick(); fetch_i = 0; endtask
  task automatic pulse_bnd(); boundary_i = 1; tick(); boundary_i = 0; endtask

  task automatic t_reset();
    check("R1 iff1", iff1_o, 0); check("R1 iff2", iff2_o, 0);
    check("R1 halted", halted_o, 0); check("R1 shadow", ei_shadow_o, 0);
    check("R1 acks", {irq_ack_o, nmi_ack_o}, 0);
    check("R1 pair", pair_o, 0); check("R1 mode", mode_o, 0);
  endtask

  task automatic t_en_dis();
    pulse_en();
    check("R2 iffs", {iff1_o, iff2_o}, 2'b11); check("R2 shadow set", ei_shadow_o, 1);
    pulse_fetch();
    check("R2 shadow clear", ei_shadow_o, 0);
    pulse_dis();
    check("R3 dis", {iff1_o, iff2_o}, 2'b00);
  endtask

  task automatic t_block_and_irq();
    pulse_en(); irq_i = 1;
    pulse_bnd();
    check("R4 after enable", irq_ack_o, 0);
    pulse_fetch(); prefix_i = 1;
    pulse_bnd();
    check("R4 prefix", irq_ack_o, 0);
    prefix_i = 0;
    pulse_bnd();
    check("R5 irq ack", irq_ack_o, 1);
    check("R5 iffs cleared", {iff1_o, iff2_o}, 2'b00);
    tick();
    check("R5 single pulse", irq_ack_o, 0);
    pulse_bnd();
    check("R5 no ack iff1=0", irq_ack_o, 0);
    irq_i = 0;
  endtask

  task automatic t_nmi();
    pulse_en(); pulse_fetch();
    nmi_i = 1; tick();
    pulse_bnd();
    check("R6 nmi ack", nmi_ack_o, 1);
    check("R6 iffs", {iff1_o, iff2_o}, 2'b01);
    restore_i = 1; tick(); restore_i = 0;
    check("R3 restore", iff1_o, 1);
    pulse_bnd();
    check("R6 level no re-accept", nmi_ack_o, 0);
    nmi_i = 0; pulse_dis();
    nmi_i = 1; tick(); nmi_i = 0;
    pulse_bnd();
    check("R6 nmi with iff1=0", nmi_ack_o, 1);
  endtask

  task automatic t_prio();
    pulse_en(); pulse_fetch();
    irq_i = 1; nmi_i = 1; tick(); nmi_i = 0;
    pulse_bnd();
    check("R7 nmi wins", {nmi_ack_o, irq_ack_o}, 2'b10);
    irq_i = 0;
  endtask

  task automatic t_refresh();
    wdata_i = 8'hFE; refresh_wr_i = 1; tick(); refresh_wr_i = 0;
    check("R9 refresh write", refresh_o, 8'hFE);
    pulse_fetch();
    check("R8 count", refresh_o, 8'hFF);
    pulse_fetch();
    check("R8 wrap keep bit7", refresh_o, 8'h80);
    wdata_i = 8'h7F; refresh_wr_i = 1; tick(); refresh_wr_i = 0;
    pulse_fetch();
    check("R8 wrap bit7 low", refresh_o, 8'h00);
    wdata_i = 8'h5A; page_wr_i = 1; tick(); page_wr_i = 0;
    check("R9 pair", pair_o, 16'h5A00);
  endtask

  task automatic t_halt();
    halt_i = 1; tick(); halt_i = 0;
    check("R10 halted", halted_o, 1);
    wdata_i = 8'h10; refresh_wr_i = 1; tick(); refresh_wr_i = 0;
    pulse_fetch();
    check("R10 dummy fetch counts", refresh_o, 8'h11);
    check("R10 still halted", halted_o, 1);
    pulse_en(); pulse_fetch(); irq_i = 1;
    pulse_bnd();
    check("R10 ack", irq_ack_o, 1);
    check("R10 halt exit", halted_o, 0);
    irq_i = 0;
  endtask

  task automatic t_mode();
    mode_i = 2; mode_wr_i = 1; tick(); mode_wr_i = 0;
    check("R11 mode 2", mode_o, 2);
    mode_i = 1; mode_wr_i = 1; tick(); mode_wr_i = 0;
    check("R11 mode 1", mode_o, 1);
  endtask

  task automatic t_restart();
    pulse_en(); halt_i = 1; tick(); halt_i = 0;
    restart_i = 1; tick(); restart_i = 0;
    t_reset();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog got=hang expected=finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_en_dis();
    t_block_and_irq();
    t_nmi();
    t_prio();
    t_refresh();
    t_halt();
    t_mode();
    t_restart();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule